// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block is the register face of a random number generator peripheral. A host reaches it over a simple word-wide bus that carries a byte address, write data, a write strobe and a read strobe. The block decodes five registers: a constant identification word, a command register, a control register, a status register and a random data port.

Software starts two background operations through the command register: seeding and self-test. Each operation moves from idle to running, and then to done after a fixed number of clock cycles that is set by a parameter. When an operation completes, a level interrupt is raised unless completions are masked. Two separate command bits lower the interrupt. A soft-reset command returns both operations and the control settings to their reset values.

The data port returns words from an internal 32-bit xorshift generator. The generator steps forward once on every read of that port. There is no entropy source, no statistical testing and no real output queue. The status register always reports a full queue of five words.

Top module: `rngc_regif`

## Requirements
- R1: Registers sit at byte offsets 0x00 (identification), 0x04 (command), 0x08 (control), 0x0C (status) and 0x14 (random data). A read of any other address returns 0, and a write to any other address changes nothing.
- R2: The identification register reads 0x1000_0240: value 1 in bits 31:28, value 2 in bits 15:8 and 0x40 in bits 7:0.
- R3: A command read returns bit 1 while seeding is running and bit 0 while self-test is running. All other bits read 0.
- R4: Control bit 6 (error mask), bit 5 (completion mask) and bit 4 (auto-seed) are written directly from write data and read back as stored. All other control bits read 0.
- R5: Status reads as follows. Bits 15:12 and 11:8 each read 5, and bit 6 reads 1. Bit 5 is set when seeding is done and bit 4 when self-test is done. Bit 1 (busy) is set while either operation runs, and bit 0 is the inverse of busy.
- R6: A command write with bit 0 (self-test) or bit 1 (seed) set puts that operation in the running state after the write edge. The operation reaches done on the clock edge ST_LAT (self-test, default 16) or SEED_LAT (seed, default 32) edges after the write edge.
- R7: A start command issued while the operation is running restarts its full latency count.
- R8: The `irq` output rises on the edge where either operation reaches done, unless control bit 5 is set. It stays high until it is cleared.
- R9: A command write with bit 5 or bit 4 set lowers `irq`. If a completion happens on the same edge, the completion wins.
- R10: Power-on reset and a command write with bit 6 set both return the operations to idle and clear all control bits. Within one command write, the soft reset applies first, then the interrupt clear, then the seed start, then the self-test start.
- R11: A read of the data port returns the current generator word and then advances it one xorshift step: x^=x<<13, x^=x>>17, x^=x<<5. The generator starts at RNG_SEED (default 0x2545_F491) after power-on reset. Other reads, all writes and soft reset leave it unchanged.
- R12: Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read. A read and a write to the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench times each operation to the exact edge. A counter that is off by one shows `busy` one read too early or too late, and it moves the `irq` rise by one cycle. A second start issued in mid-run must delay completion by the full latency, so a design that ignores the restart completes early. A combined command that both resets and starts must leave self-test running with the control bits cleared, and a design with the wrong priority shows an idle operation or a stale mask. The data port is checked against a generator model across interleaved reads of other registers and a write to the port, so a design that steps on the wrong access returns a shifted sequence.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_DONE = 2'd2
  } op_state_t;

  localparam int unsigned DW = 32;

  localparam int unsigned OFF_IDENT  = 'h00;
  localparam int unsigned OFF_CMD    = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_STATUS = 'h0C;
  localparam int unsigned OFF_DATA   = 'h14;

  localparam logic [DW-1:0] IDENT_WORD = (32'd1 << 28) | (32'd2 << 8) | 32'h40;

  localparam int unsigned CMD_SRST   = 6;
  localparam int unsigned CMD_CLRERR = 5;
  localparam int unsigned CMD_CLRINT = 4;
  localparam int unsigned CMD_SEED   = 1;
  localparam int unsigned CMD_TEST   = 0;

  localparam int unsigned CTL_MERR   = 6;
  localparam int unsigned CTL_MDONE  = 5;
  localparam int unsigned CTL_AUTO   = 4;

  localparam int unsigned N_OPS      = 2;
  localparam int unsigned OP_TEST    = 0;
  localparam int unsigned OP_SEED    = 1;

  localparam logic [3:0] FIFO_WORDS  = 4'd5;

endpackage

// File: rtl/rngc_op_fsm.sv
module rngc_op_fsm
  import rngc_pkg::*;
#(
  parameter int unsigned LAT = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      start_i,
  output op_state_t state_o,
  output logic      done_o
);

  localparam int unsigned CNT_W = (LAT < 2) ? 1 : $clog2(LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  op_state_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             st_en, cnt_en;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_o = 1'b0;
    if (start_i) begin
      st_n  = OP_RUN;
      cnt_n = CNT_LOAD;
    end else if (clr_i) begin
      st_n  = OP_IDLE;
      cnt_n = '0;
    end else if (st_q == OP_RUN) begin
      if (cnt_q == '0) begin
        st_n   = OP_DONE;
        done_o = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  assign st_en  = (st_n != st_q);
  assign cnt_en = (cnt_n != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= OP_IDLE;
    end else if (st_en) begin
      st_q <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/rngc_xorshift.sv
module rngc_xorshift #(
  parameter logic [31:0] SEED = 32'h2545_F491
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  output logic [31:0] value_o
);

  logic [31:0] s_q, s_n;
  logic [31:0] mix_a, mix_b, mix_c;

  always_comb begin
    mix_a = s_q ^ (s_q << 13);
    mix_b = mix_a ^ (mix_a >> 17);
    mix_c = mix_b ^ (mix_b << 5);
    s_n   = mix_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= SEED;
    end else if (step_i) begin
      s_q <= s_n;
    end
  end

  assign value_o = s_q;

endmodule

// File: rtl/rngc_irq_ctl.sv
module rngc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  logic irq_q, irq_n, irq_en;

  always_comb begin
    irq_n = irq_q;
    if (set_i) begin
      irq_n = 1'b1;
    end else if (clr_i) begin
      irq_n = 1'b0;
    end
  end

  assign irq_en = (irq_n != irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_n;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/rngc_regif.sv
module rngc_regif
  import rngc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ST_LAT   = 16,
  parameter int unsigned SEED_LAT = 32,
  parameter logic [31:0] RNG_SEED = 32'h2545_F491
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFF_IDENT);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);

  // reset synchronizer: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic hit_ident, hit_cmd, hit_ctrl, hit_status, hit_data;
  logic wr_cmd, wr_ctrl, rd_data;

  assign hit_ident  = (bus_addr == A_IDENT);
  assign hit_cmd    = (bus_addr == A_CMD);
  assign hit_ctrl   = (bus_addr == A_CTRL);
  assign hit_status = (bus_addr == A_STATUS);
  assign hit_data   = (bus_addr == A_DATA);

  assign wr_cmd  = bus_wr & hit_cmd;
  assign wr_ctrl = bus_wr & hit_ctrl;
  assign rd_data = bus_rd & hit_data;

  // command decode, applied in order: reset, clear, seed, self-test
  logic soft_rst, irq_clr;
  logic [N_OPS-1:0] op_go;

  assign soft_rst            = wr_cmd & bus_wdata[CMD_SRST];
  assign irq_clr             = wr_cmd & (bus_wdata[CMD_CLRERR] | bus_wdata[CMD_CLRINT]);
  assign op_go[OP_SEED]      = wr_cmd & bus_wdata[CMD_SEED];
  assign op_go[OP_TEST]      = wr_cmd & bus_wdata[CMD_TEST];

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

  // control register
  logic ctl_merr_q, ctl_mdone_q, ctl_auto_q;
  logic ctl_merr_n, ctl_mdone_n, ctl_auto_n;
  logic ctl_en;

  always_comb begin
    ctl_merr_n  = ctl_merr_q;
    ctl_mdone_n = ctl_mdone_q;
    ctl_auto_n  = ctl_auto_q;
    if (wr_ctrl) begin
      ctl_merr_n  = bus_wdata[CTL_MERR];
      ctl_mdone_n = bus_wdata[CTL_MDONE];
      ctl_auto_n  = bus_wdata[CTL_AUTO];
    end else if (soft_rst) begin
      ctl_merr_n  = 1'b0;
      ctl_mdone_n = 1'b0;
      ctl_auto_n  = 1'b0;
    end
  end

  assign ctl_en = wr_ctrl | soft_rst;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_merr_q  <= 1'b0;
      ctl_mdone_q <= 1'b0;
      ctl_auto_q  <= 1'b0;
    end else if (ctl_en) begin
      ctl_merr_q  <= ctl_merr_n;
      ctl_mdone_q <= ctl_mdone_n;
      ctl_auto_q  <= ctl_auto_n;
    end
  end

  logic ctl_mask_done;
  assign ctl_mask_done = ctl_mdone_q;

  // operation state machines
  op_state_t        op_state [N_OPS];
  logic [N_OPS-1:0] op_done;
  logic [N_OPS-1:0] op_running;
  logic [N_OPS-1:0] op_finished;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    localparam int unsigned LAT = (g == OP_SEED) ? SEED_LAT : ST_LAT;
    rngc_op_fsm #(.LAT(LAT)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr_i   (soft_rst),
      .start_i (op_go[g]),
      .state_o (op_state[g]),
      .done_o  (op_done[g])
    );
    assign op_running[g]  = (op_state[g] == OP_RUN);
    assign op_finished[g] = (op_state[g] == OP_DONE);
  end

  op_state_t st_state, sd_state;
  assign st_state = op_state[OP_TEST];
  assign sd_state = op_state[OP_SEED];

  // interrupt
  logic irq_set;
  assign irq_set = (|op_done) & ~ctl_mdone_q;

  rngc_irq_ctl u_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .irq_o (irq)
  );

  // random source
  logic [DW-1:0] rng_word;

  rngc_xorshift #(.SEED(RNG_SEED)) u_rng (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step_i  (rd_data),
    .value_o (rng_word)
  );

  // readback
  logic busy;
  logic [DW-1:0] cmd_word, ctl_word, stat_word, rd_val;

  assign busy = |op_running;

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_SEED] = op_running[OP_SEED];
    cmd_word[CMD_TEST] = op_running[OP_TEST];
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_MERR]  = ctl_merr_q;
    ctl_word[CTL_MDONE] = ctl_mdone_q;
    ctl_word[CTL_AUTO]  = ctl_auto_q;
  end

  always_comb begin
    stat_word        = '0;
    stat_word[15:12] = FIFO_WORDS;
    stat_word[11:8]  = FIFO_WORDS;
    stat_word[6]     = 1'b1;
    stat_word[5]     = op_finished[OP_SEED];
    stat_word[4]     = op_finished[OP_TEST];
    stat_word[1]     = busy;
    stat_word[0]     = ~busy;
  end

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      hit_ident:  rd_val = IDENT_WORD;
      hit_cmd:    rd_val = cmd_word;
      hit_ctrl:   rd_val = ctl_word;
      hit_status: rd_val = stat_word;
      hit_data:   rd_val = rng_word;
      default:    rd_val = '0;
    endcase
  end

  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/rngc_regif_chk.sv
module rngc_regif_chk
  import rngc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input op_state_t         st_state,
  input op_state_t         sd_state,
  input logic              mask_done
);

  AST_IDENT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'(OFF_IDENT)) |-> bus_rdata == IDENT_WORD); // R2

  AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'(OFF_CMD)) |-> bus_rdata[31:2] == '0); // R3

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'(OFF_CTRL)) |-> (bus_rdata & ~32'h70) == '0); // R4

  AST_STATUS_BUSY_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'(OFF_STATUS)) |-> (bus_rdata[1] ^ bus_rdata[0]) && bus_rdata[6]); // R5

  AST_TEST_RUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_state) != OP_RUN && st_state == OP_RUN) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata[0])); // R6

  AST_IRQ_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (st_state == OP_DONE || sd_state == OP_DONE) && !$past(mask_done)); // R8

  AST_IRQ_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_CMD) && (bus_wdata[5] || bus_wdata[4]))); // R9

  AST_DATA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == ADDR_W'(OFF_DATA)) |-> bus_rdata != '0); // R11

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R12

endmodule

bind rngc_regif rngc_regif_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .st_state  (st_state),
  .sd_state  (sd_state),
  .mask_done (ctl_mask_done)
);

// File: tb/rngc_regif_tb_top.sv
`timescale 1ns/1ps
module rngc_regif_tb_top;

  localparam logic [31:0] SEED = 32'h2545_F491;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #10 clk = ~clk;

  rngc_regif #(.ADDR_W(8), .ST_LAT(16), .SEED_LAT(32), .RNG_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] got;
  logic        got_irq;
  logic [31:0] xs;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read-check, 2 idle
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    {2'd1, 8'h00, 32'h0,        32'h1000_0240, 8'd2},  // R2
    {2'd1, 8'h04, 32'h0,        32'h0,         8'd3},  // R3
    {2'd1, 8'h08, 32'h0,        32'h0,         8'd4},  // R4
    {2'd1, 8'h0C, 32'h0,        32'h5541,      8'd5},  // R5
    {2'd1, 8'h10, 32'h0,        32'h0,         8'd1},  // R1
    {2'd0, 8'h10, 32'hFFFF_FFFF, 32'h0,        8'd1},
    {2'd1, 8'h10, 32'h0,        32'h0,         8'd1},  // R1
    {2'd0, 8'h08, 32'hFFFF_FFFF, 32'h0,        8'd4},
    {2'd1, 8'h08, 32'h0,        32'h70,        8'd4},  // R4
    {2'd0, 8'h08, 32'h10,       32'h0,         8'd4},
    {2'd1, 8'h08, 32'h0,        32'h10,        8'd4},  // R4
    {2'd0, 8'h04, 32'h1,        32'h0,         8'd6},
    {2'd2, 8'h00, 32'd14,       32'h0,         8'd6},
    {2'd1, 8'h04, 32'h0,        32'h1,         8'd3},  // R3
    {2'd1, 8'h0C, 32'h0,        32'h5542,      8'd6},  // R6 still running
    {2'd1, 8'h0C, 32'h0,        32'h5551,      8'd6},  // R6 done
    {2'd1, 8'h04, 32'h0,        32'h0,         8'd3},
    {2'd0, 8'h04, 32'h2,        32'h0,         8'd6},
    {2'd2, 8'h00, 32'd29,       32'h0,         8'd6},
    {2'd1, 8'h04, 32'h0,        32'h2,         8'd3},  // R3
    {2'd1, 8'h0C, 32'h0,        32'h5552,      8'd6},
    {2'd1, 8'h0C, 32'h0,        32'h5552,      8'd6},
    {2'd1, 8'h0C, 32'h0,        32'h5571,      8'd6},  // R6 seed done
    {2'd1, 8'h04, 32'h0,        32'h0,         8'd3},
    {2'd0, 8'h04, 32'h40,       32'h0,         8'd10},
    {2'd1, 8'h0C, 32'h0,        32'h5541,      8'd10}, // R10
    {2'd1, 8'h08, 32'h0,        32'h0,         8'd10}  // R10
  };

  function automatic logic [31:0] xs_next(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic step(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #2;
    got = bus_rdata;
    got_irq = irq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    step(1'b0, 1'b1, a, 32'h0);
    check(req, got, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R10 reset irq", {31'h0, irq}, 32'h0);
    check("R12 reset rdata", bus_rdata, 32'h0);
    xs = SEED;

    // table walk
    for (int v = 0; v < NV; v++) begin
      case (VEC[v].kind)
        2'd0: step(1'b1, 1'b0, VEC[v].addr, VEC[v].data);
        2'd1: begin
          step(1'b0, 1'b1, VEC[v].addr, 32'h0);
          check($sformatf("R%0d vec%0d", VEC[v].req, v), got, VEC[v].exp);
        end
        default: idle(int'(VEC[v].data));
      endcase
    end

    // R9: both clear bits lower irq; irq was raised by completions above
    step(1'b0, 1'b0, 8'h00, 32'h0);
    check("R8 irq held after completions", {31'h0, got_irq}, 32'h1);
    step(1'b1, 1'b0, 8'h04, 32'h10);
    check("R9 clear via bit4", {31'h0, got_irq}, 32'h0);

    // R8: exact completion edge
    step(1'b1, 1'b0, 8'h04, 32'h1);
    idle(15);
    check("R8 irq before done edge", {31'h0, got_irq}, 32'h0);
    idle(1);
    check("R8 irq at done edge", {31'h0, got_irq}, 32'h1);
    step(1'b1, 1'b0, 8'h04, 32'h20);
    check("R9 clear via bit5", {31'h0, got_irq}, 32'h0);

    // R8: mask done suppresses irq
    step(1'b1, 1'b0, 8'h08, 32'h20);
    step(1'b1, 1'b0, 8'h04, 32'h2);
    idle(40);
    check("R8 masked irq stays low", {31'h0, got_irq}, 32'h0);
    rd_check("R8 masked completion visible", 8'h0C, 32'h5571);

    // R7: restart in mid-run
    step(1'b1, 1'b0, 8'h04, 32'h40);
    step(1'b1, 1'b0, 8'h04, 32'h1);
    idle(9);
    step(1'b1, 1'b0, 8'h04, 32'h1);
    idle(14);
    rd_check("R7 running after restart", 8'h0C, 32'h5542);
    rd_check("R7 running at last edge", 8'h0C, 32'h5542);
    check("R7 irq at restarted done edge", {31'h0, got_irq}, 32'h1);
    rd_check("R7 done after restart", 8'h0C, 32'h5551);

    // R10: ordering within one command write
    step(1'b1, 1'b0, 8'h08, 32'h70);
    step(1'b1, 1'b0, 8'h04, 32'h71);
    check("R10 clear follows reset", {31'h0, got_irq}, 32'h0);
    rd_check("R10 start follows reset", 8'h04, 32'h1);
    rd_check("R10 control cleared", 8'h08, 32'h0);

    // R12: read and write same register in one cycle
    step(1'b1, 1'b1, 8'h08, 32'h20);
    check("R12 read before write", got, 32'h0);
    rd_check("R12 write landed", 8'h08, 32'h20);
    idle(3);
    check("R12 rdata holds", got, 32'h20);

    // R11: generator sequence
    rd_check("R11 first word", 8'h14, xs);
    xs = xs_next(xs);
    rd_check("R11 ident read", 8'h00, 32'h1000_0240);
    rd_check("R11 after other read", 8'h14, xs);
    xs = xs_next(xs);
    step(1'b1, 1'b0, 8'h14, 32'hDEAD_BEEF);
    step(1'b1, 1'b0, 8'h04, 32'h40);
    rd_check("R11 after write and soft reset", 8'h14, xs);
    xs = xs_next(xs);
    rd_check("R11 fourth word", 8'h14, xs);
    rd_check("R1 unmapped 0x18", 8'h18, 32'h0);

    step(1'b0, 1'b0, 8'h00, 32'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule